// File: doc/BRIEF.md
# Synchronous Serial Shift Interface

This block is an 8-bit synchronous serial shifter with one data input pin, one data output pin and one shift-clock pin. Software loads a byte into the shift register through a small register port, picks master or slave operation and a clock rate, and then sets a busy bit. The transfer moves one bit out and one bit in per shift-clock period, most significant bit first.

As a master, the block makes the shift clock itself. It divides an instruction-cycle enable pulse, `cycTick`, which the surrounding chip asserts once per instruction cycle, one cycle in ten of the core clock. As a slave, it passes an externally driven shift clock through a two-flop synchronizer and acts on the edges it detects.

The block clears the busy bit itself once eight bits have moved. Software may clear it sooner, which stops the clock and leaves a shorter frame in the shift register. A function-select bit decides whether the pins belong to the shifter. While that bit is clear, the shifter holds its outputs low and will not start a transfer.

Top module: `ser_shift_top`

## Requirements
- R1: After reset the data register and the control register both read 0, and `sdOut`, `sclkOut` and `sclkOe` are low.
- R2: `regAddr`=0 selects the data register and `regAddr`=1 selects the control register. The control fields are: bit 0 busy, bits 2:1 rate, bit 3 master, bit 4 select. All other control bits read 0.
- R3: While select is 0, `sdOut` and `sclkOe` stay low. A control write that sets busy with select 0 leaves busy at 0, and no shift-clock edges appear.
- R4: In master mode the shift-clock period is 2 `cycTick` pulses for rate 00, 4 for rate 01 and 8 for rate 1x. Every rising edge of `sclkOut` follows a clock cycle in which `cycTick` was high.
- R5: Data moves MSB first. `sdIn` is sampled on each rising shift-clock edge, and the register shifts left on each falling edge, taking the sampled bit into bit 0. `sdOut` shows bit 7 and changes only on a falling edge while a transfer runs. After a full transfer the data register holds the received byte.
- R6: A transfer makes exactly eight rising shift-clock edges. The block clears busy by itself on the eighth falling edge.
- R7: Writing the control register with busy 0 during a transfer stops it at once. `sclkOut` goes low and stays low, and the data register keeps the partly shifted value: after n falls this is the original byte shifted left by n with the n received bits below it.
- R8: `sclkOut` is low whenever busy is 0.
- R9: In slave mode (master 0, select 1) the block shifts on edges of `sclkIn` after a two-flop synchronizer. Edges of `sclkIn` while busy is 0 leave the data register unchanged.
- R10: Writes to the data register while busy is 1 have no effect.
- R11: `sclkOe` is high exactly when both select and master are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cycTick | input | 1 | One-cycle pulse per instruction cycle |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 data, 1 control |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Read data of the selected register |
| sdIn | input | 1 | Serial data input |
| sdOut | output | 1 | Serial data output |
| sclkIn | input | 1 | External shift clock (slave mode) |
| sclkOut | output | 1 | Generated shift clock (master mode) |
| sclkOe | output | 1 | Drive enable for the shift-clock pin |

## Verification
Master transfers run at all four rate codes with different transmit and receive bytes, so a wrong divider ratio shows up as a measured period error and a wrong bit order shows up as a mirrored byte on either side. Because the receive pattern differs from the loaded byte, the check separates a sample taken on the rising edge from a shift or loopback on the wrong edge. Slave transfers use a slow external clock, and stray edges sent while idle show whether the synchronized edge detector is gated by busy. An early abort after three bits and a data write in the middle of a transfer test the partial-frame value and the write lockout, and a start attempted with select clear tests the pin gating.

// File: rtl/ser_shift_pkg.sv
package ser_shift_pkg;
  // register select values
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  // control register field positions
  localparam int CB_BUSY    = 0;
  localparam int CB_RATE_LO = 1;
  localparam int CB_RATE_HI = 2;
  localparam int CB_MASTER  = 3;
  localparam int CB_SELECT  = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // parallel load from register port
    logic sample;  // capture serial input
    logic shift;   // shift left, taking the captured bit
  } strobe_t;
endpackage

// File: rtl/ser_shift_dp.sv
module ser_shift_dp
  import ser_shift_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sdIn,
  output logic [DATA_W-1:0] shiftQ,
  output logic              msbOut
);
  logic sampleQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ  <= '0;
      sampleQ <= 1'b0;
    end else begin
      if (strb.sample) sampleQ <= sdIn;
      if (strb.load)       shiftQ <= wrData;
      else if (strb.shift) shiftQ <= {shiftQ[DATA_W-2:0], sampleQ};
    end
  end

  assign msbOut = shiftQ[DATA_W-1];
endmodule

// File: rtl/ser_shift_ctrl.sv
module ser_shift_ctrl
  import ser_shift_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HALF_UNIT   = 1   // ticks per half period at the fastest rate
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycTick,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              sclkIn,
  output strobe_t           strb,
  output logic              busyQ,
  output logic [1:0]        rateQ,
  output logic              masterQ,
  output logic              selectQ,
  output logic              sclkQ
);
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int HALF_W = $clog2(4 * HALF_UNIT + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncPrevQ;
  logic [CNT_W-1:0]       bitCntQ;
  logic [HALF_W-1:0]      halfCntQ;
  logic [HALF_W-1:0]      halfLen;
  logic ctrlWr, newBusy, startReq, halfDone;
  logic mEdge, mRise, mFall, extRise, extFall, sRise, sFall;
  logic doShift, lastShift;

  // half-period length in ticks per rate code
  always_comb begin
    case (rateQ)
      2'b00:   halfLen = HALF_W'(HALF_UNIT);
      2'b01:   halfLen = HALF_W'(2 * HALF_UNIT);
      default: halfLen = HALF_W'(4 * HALF_UNIT);
    endcase
  end

  assign ctrlWr   = regWrEn && (regAddr == ADDR_CTRL);
  assign newBusy  = regWrData[CB_BUSY] & regWrData[CB_SELECT];
  assign startReq = ctrlWr && newBusy && !busyQ;
  assign halfDone = (halfCntQ == halfLen - HALF_W'(1));

  // master edges come from the divided tick
  assign mEdge = busyQ && masterQ && cycTick && !ctrlWr && halfDone;
  assign mRise = mEdge && !sclkQ;
  assign mFall = mEdge && sclkQ;

  // slave edges come from the synchronized external clock
  assign extRise = syncQ[SYNC_STAGES-1] && !syncPrevQ;
  assign extFall = !syncQ[SYNC_STAGES-1] && syncPrevQ;
  assign sRise   = busyQ && !masterQ && !ctrlWr && extRise;
  assign sFall   = busyQ && !masterQ && !ctrlWr && extFall;

  assign doShift   = mFall || sFall;
  assign lastShift = doShift && (bitCntQ == CNT_W'(DATA_W - 1));

  always_comb begin
    strb.load   = regWrEn && (regAddr == ADDR_DATA) && !busyQ;
    strb.sample = mRise || sRise;
    strb.shift  = doShift;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ     <= '0;
      syncPrevQ <= 1'b0;
    end else begin
      syncQ     <= {syncQ[SYNC_STAGES-2:0], sclkIn};
      syncPrevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      rateQ   <= 2'b00;
      masterQ <= 1'b0;
      selectQ <= 1'b0;
    end else if (ctrlWr) begin
      busyQ   <= newBusy;
      rateQ   <= regWrData[CB_RATE_HI:CB_RATE_LO];
      masterQ <= regWrData[CB_MASTER];
      selectQ <= regWrData[CB_SELECT];
    end else if (lastShift) begin
      busyQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCntQ  <= '0;
      halfCntQ <= '0;
      sclkQ    <= 1'b0;
    end else begin
      if (startReq)     bitCntQ <= '0;
      else if (doShift) bitCntQ <= bitCntQ + 1'b1;

      if (!busyQ || ctrlWr)          halfCntQ <= '0;
      else if (masterQ && cycTick)   halfCntQ <= halfDone ? '0 : halfCntQ + 1'b1;

      if (ctrlWr && !newBusy)        sclkQ <= 1'b0;
      else if (mRise)                sclkQ <= 1'b1;
      else if (mFall || lastShift)   sclkQ <= 1'b0;
    end
  end
endmodule

// File: rtl/ser_shift_top.sv
module ser_shift_top
  import ser_shift_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HALF_UNIT   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycTick,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              sdIn,
  output logic              sdOut,
  input  logic              sclkIn,
  output logic              sclkOut,
  output logic              sclkOe
);
  strobe_t           strb;
  logic              busyQ, masterQ, selectQ, sclkQ, msbOut;
  logic [1:0]        rateQ;
  logic [DATA_W-1:0] shiftQ, ctrlRd;

  ser_shift_ctrl #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .HALF_UNIT(HALF_UNIT)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cycTick(cycTick),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .sclkIn(sclkIn), .strb(strb), .busyQ(busyQ), .rateQ(rateQ),
    .masterQ(masterQ), .selectQ(selectQ), .sclkQ(sclkQ)
  );

  ser_shift_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData),
    .sdIn(sdIn), .shiftQ(shiftQ), .msbOut(msbOut)
  );

  always_comb begin
    ctrlRd = '0;
    ctrlRd[CB_BUSY]               = busyQ;
    ctrlRd[CB_RATE_HI:CB_RATE_LO] = rateQ;
    ctrlRd[CB_MASTER]             = masterQ;
    ctrlRd[CB_SELECT]             = selectQ;
  end

  assign regRdData = (regAddr == ADDR_CTRL) ? ctrlRd : shiftQ;
  assign sdOut     = selectQ & msbOut;
  assign sclkOe    = selectQ & masterQ;
  assign sclkOut   = sclkOe & sclkQ;
endmodule

// File: rtl/ser_shift_chk.sv
module ser_shift_chk (
  input logic clk,
  input logic rstN,
  input logic cycTick,
  input logic sdOut,
  input logic sclkOut,
  input logic sclkOe,
  input logic busyQ,
  input logic masterQ,
  input logic selectQ
);
  AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ |-> !sclkOut); // R8

  AST_UNSELECTED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !selectQ |-> (!sclkOe && !sdOut)); // R3

  AST_BUSY_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> selectQ); // R3

  AST_RISE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclkOut) |-> $past(cycTick)); // R4

  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (masterQ && busyQ && $past(busyQ) && !$stable(sdOut)) |-> $fell(sclkOut)); // R5
endmodule

bind ser_shift_top ser_shift_chk chk_i (
  .clk(clk), .rstN(rstN), .cycTick(cycTick), .sdOut(sdOut),
  .sclkOut(sclkOut), .sclkOe(sclkOe), .busyQ(busyQ),
  .masterQ(masterQ), .selectQ(selectQ)
);

// File: tb/ser_shift_top_tb_top.sv
module ser_shift_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cycTick = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regAddr = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       sdIn = 1'b0;
  logic       sdOut;
  logic       sclkIn = 1'b0;
  logic       sclkOut;
  logic       sclkOe;

  int nChk = 0;
  int nFail = 0;
  int cyc = 0;
  int tickCnt = 0;

  ser_shift_top dut_i (
    .clk(clk), .rstN(rstN), .cycTick(cycTick), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .sdIn(sdIn), .sdOut(sdOut), .sclkIn(sclkIn), .sclkOut(sclkOut), .sclkOe(sclkOe)
  );

  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) cyc = cyc + 1;

  // one tick every ten core clocks
  always @(negedge clk) begin
    tickCnt = (tickCnt == 9) ? 0 : tickCnt + 1;
    cycTick = (tickCnt == 9);
  end

  // ---------------- scoreboard ----------------
  typedef struct { string req; int val; } item_t;
  item_t expQ[$];
  int    gotVal;
  event  gotEv;

  task automatic pushExp(input string req, input int val);
    item_t it;
    it.req = req; it.val = val;
    expQ.push_back(it);
  endtask

  task automatic postAct(input int val);
    gotVal = val;
    -> gotEv;
    #1;
  endtask

  always begin
    item_t it;
    @(gotEv);
    nChk++;
    if (expQ.size() == 0) begin
      nFail++;
      $display("FAIL scoreboard empty: actual=%0d expected=none", gotVal);
    end else begin
      it = expQ.pop_front();
      if (it.val !== gotVal) begin
        nFail++;
        $display("FAIL %s: actual=%0h expected=%0h", it.req, gotVal, it.val);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- register access ----------------
  task automatic wrReg(input logic a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic waitIdle();
    logic [7:0] v;
    for (int i = 0; i < 5000; i++) begin
      rdReg(1'b1, v);
      if (!v[0]) break;
    end
  endtask

  // ---------------- master-side peripheral model ----------------
  logic [7:0] mdlPat = 8'h00;
  logic [7:0] capByte = 8'h00;
  logic       mdlOn = 1'b0;
  int         mdlIdx = 0;
  int         riseCnt = 0;
  int         fallCnt = 0;
  int         rise0 = 0;
  int         rise1 = 0;

  always @(posedge sclkOut) if (mdlOn) begin
    capByte = {capByte[6:0], sdOut};
    if (riseCnt == 0) rise0 = cyc;
    if (riseCnt == 1) rise1 = cyc;
    riseCnt++;
  end

  always @(negedge sclkOut) if (mdlOn) begin
    fallCnt++;
    mdlIdx++;
    if (mdlIdx < 8) sdIn = mdlPat[7 - mdlIdx];
  end

  task automatic armModel(input logic [7:0] pat);
    mdlPat = pat; mdlIdx = 0; sdIn = pat[7];
    riseCnt = 0; fallCnt = 0; capByte = 8'h00; mdlOn = 1'b1;
  endtask

  // full master transfer at one rate code
  task automatic runMaster(input logic [1:0] rate, input logic [7:0] tx,
                           input logic [7:0] pat, input int period);
    logic [7:0] v;
    wrReg(1'b0, tx);
    armModel(pat);
    wrReg(1'b1, 8'h19 | {5'b0, rate, 1'b0});
    waitIdle();
    mdlOn = 1'b0;
    rdReg(1'b0, v);
    pushExp("R5 received byte", pat);     postAct(v);
    pushExp("R5 transmitted byte", tx);   postAct(capByte);
    pushExp("R6 rising edge count", 8);   postAct(riseCnt);
    pushExp("R4 shift clock period", period); postAct(rise1 - rise0);
    chk("R8 clock low after done", sclkOut, 0);
  endtask

  // ---------------- slave-side clock driver ----------------
  task automatic runSlave(input logic [7:0] tx, input logic [7:0] pat);
    logic [7:0] v;
    logic [7:0] cap;
    cap = 8'h00;
    wrReg(1'b0, tx);
    wrReg(1'b1, 8'h11);   // select, slave, busy
    chk("R11 no clock drive in slave", sclkOe, 0);
    for (int b = 0; b < 8; b++) begin
      @(negedge clk); sdIn = pat[7 - b];
      repeat (20) @(negedge clk);
      cap = {cap[6:0], sdOut};
      sclkIn = 1'b1;
      repeat (20) @(negedge clk);
      sclkIn = 1'b0;
    end
    repeat (10) @(negedge clk);
    rdReg(1'b1, v);
    pushExp("R6 slave busy cleared", 0);    postAct(v[0]);
    rdReg(1'b0, v);
    pushExp("R9 slave received byte", pat); postAct(v);
    pushExp("R9 slave transmitted byte", tx); postAct(cap);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [7:0] v;
    int r;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 sdOut at reset", sdOut, 0);
    chk("R1 sclkOut at reset", sclkOut, 0);
    chk("R1 sclkOe at reset", sclkOe, 0);
    rstN = 1'b1;
    rdReg(1'b1, v); chk("R1 control at reset", v, 8'h00);
    rdReg(1'b0, v); chk("R1 data at reset", v, 8'h00);

    // R2: field layout and unused bits
    wrReg(1'b1, 8'h1E);
    rdReg(1'b1, v); chk("R2 control readback", v, 8'h1E);
    chk("R11 clock drive with select and master", sclkOe, 1);
    wrReg(1'b1, 8'hEE);
    rdReg(1'b1, v); chk("R2 unused bits read zero", v, 8'h0E);

    // R3: start attempt with select clear
    wrReg(1'b0, 8'h80);
    wrReg(1'b1, 8'h09);
    rdReg(1'b1, v); chk("R3 busy stays clear", v[0], 0);
    #1;
    chk("R3 sdOut held low", sdOut, 0);
    chk("R3 no clock drive", sclkOe, 0);
    armModel(8'h00);
    repeat (200) @(negedge clk);
    mdlOn = 1'b0;
    chk("R3 no shift clock edges", riseCnt, 0);

    // R4/R5/R6 at every rate code
    runMaster(2'b00, 8'hA5, 8'h3C, 20);
    runMaster(2'b01, 8'h96, 8'hE1, 40);
    runMaster(2'b10, 8'h01, 8'h80, 80);
    runMaster(2'b11, 8'h7E, 8'hC3, 80);

    // R10: data write during a transfer
    wrReg(1'b0, 8'h5A);
    armModel(8'h69);
    wrReg(1'b1, 8'h19);
    wait (riseCnt == 2);
    wrReg(1'b0, 8'hFF);
    waitIdle();
    mdlOn = 1'b0;
    rdReg(1'b0, v);
    pushExp("R10 write during transfer ignored", 8'h69); postAct(v);
    pushExp("R10 transmitted byte intact", 8'h5A);      postAct(capByte);

    // R7: abort after three bits
    wrReg(1'b0, 8'hC5);
    armModel(8'hB2);
    wrReg(1'b1, 8'h1D);   // rate 10
    wait (fallCnt == 3);
    wrReg(1'b1, 8'h1C);
    rdReg(1'b1, v); chk("R7 busy cleared by abort", v[0], 0);
    rdReg(1'b0, v);
    pushExp("R7 partial frame", {8'hC5 << 3} | 8'h05); postAct(v);
    r = riseCnt;
    repeat (400) @(negedge clk);
    mdlOn = 1'b0;
    chk("R7 no edges after abort", riseCnt, r);
    chk("R8 clock low after abort", sclkOut, 0);

    // R9: idle external edges ignored
    wrReg(1'b1, 8'h10);
    wrReg(1'b0, 8'h3C);
    for (int k = 0; k < 3; k++) begin
      repeat (10) @(negedge clk); sclkIn = 1'b1;
      repeat (10) @(negedge clk); sclkIn = 1'b0;
    end
    repeat (10) @(negedge clk);
    rdReg(1'b0, v); chk("R9 idle edges ignored", v, 8'h3C);
    chk("R11 slave never drives clock", sclkOe, 0);

    // R9: slave transfers
    runSlave(8'h4D, 8'h2B);
    runSlave(8'hF0, 8'h0F);

    repeat (5) @(negedge clk);
    if (expQ.size() != 0) begin
      nChk++; nFail++;
      $display("FAIL scoreboard leftover: actual=%0d expected=0", expQ.size());
    end
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule